// File: doc/BRIEF.md
# GOB Sequence Lock and Recovery Controller

This block decides whether a video demultiplexer is locked to a picture/GOB stream that an upstream parser has already split into start-code events. The parser reports picture and GOB start codes, together with the GOB number, and it pulses fault lines when decoding goes wrong. From these inputs the controller keeps a lock state, a saturating fault count and its own GOB numbering. It also gates the parser on and off.

Lock can be lost in several ways: a parser fault, a GOB number that is illegal for the picture format, or a picture start that arrives in the middle of a picture. The host chooses where recovery resumes: at the next picture start or at the next GOB start. When lock returns, the controller first emits one fixed-macroblock fill request for each GOB that was skipped. After a loss it rebuilds its numbering and then numbers GOBs by itself. Host bits can hold the block off the stream, freeze it at picture boundaries, restrict the error pulse to framing errors, and clear the fault count.

Top module: `gob_lock_ctrl`

## Requirements
- R1: After reset `locked_o`=0, `err_no`=1, `fault_cnt_o`=0, `fill_valid_o`=0, `parser_en_o`=1 and `cur_gob_o`=0. The first lock happens only on a picture start; GOB starts before that are ignored. Every input pulse is sampled on a rising edge, and the outputs reflect it right after that same edge.
- R2: While locked, a pulse on any of `flt_missing_i`, `flt_nomatch_i` or `flt_coef_i` clears `locked_o`, increments `fault_cnt_o` and gives one `err_no` low cycle. While unlocked these pulses are ignored.
- R3: `fault_cnt_o` saturates at CNT_MAX (256) and reads 0 after a `cnt_clr_i` pulse.
- R4: While locked, a picture start that arrives when `cur_gob_o` is not the last GOB of the format drops `locked_o` for exactly one cycle. It also increments the count, pulses `err_no` and requests fill for the rest of that picture. `cur_gob_o` becomes 0.
- R5: After a lock gain, the first GOB number is taken as `cur_gob_o`. While sequence checking is active, each GOB number that is not the successor of `cur_gob_o` replaces it and starts a new sequence. The first in-sequence number ends checking.
- R6: Once checking has ended, each GOB start advances `cur_gob_o` to its successor (CIF: 1..12 then back to 1; QCIF: 1,3,5 then back to 1), whatever number the stream carries.
- R7: While `hold_i` is high, `locked_o`=0, `parser_en_o`=0 and all events are ignored. After the hold, only a picture start regains lock, even in GOB recovery mode.
- R8: With `recover_gob_i`=0, recovery after a fault waits for a picture start. With `recover_gob_i`=1, a valid GOB start also regains lock, and its number becomes `cur_gob_o`.
- R9: Legal GOB numbers are 1..12 when `qcif_i`=0, and 1, 3, 5 when `qcif_i`=1. While locked, an illegal number clears `locked_o` and pulses `err_no`, but does not change `fault_cnt_o`.
- R10: On a lock gain, fill requests run from the successor of the GOB held at the loss up to the target. The target is, exclusively, the regaining GOB, or the end of the picture for a picture start. If the loss happened right after a picture start, the whole picture is filled. The requests come one per cycle with `fill_valid_o`=1, starting the cycle after the event, and `parser_en_o`=0 while they run. The first lock after reset and a lock gain on freeze release issue no fill.
- R11: `err_no` is an active-low pulse, one cycle long, triggered by a lock-loss event from R2, R4 or R9 or by `frame_err_i`. With `err_frame_only_i`=1, only `frame_err_i` drives it.
- R12: A picture start that arrives while `freeze_i`=1 drops or withholds lock. The first picture start with `freeze_i`=0 after that regains lock with no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pic_start_i | input | 1 | Picture start code seen (pulse) |
| gob_start_i | input | 1 | GOB start code seen (pulse) |
| gob_num_i | input | 4 | GOB number carried with gob_start_i |
| flt_missing_i | input | 1 | Expected start code missing |
| flt_nomatch_i | input | 1 | Codeword had no valid match |
| flt_coef_i | input | 1 | Too many coefficients in a block |
| frame_err_i | input | 1 | Framing error from the aligner |
| qcif_i | input | 1 | 1 = QCIF numbering, 0 = CIF |
| recover_gob_i | input | 1 | 1 = resume at GOB start, 0 = at picture start |
| hold_i | input | 1 | Force loss and discard |
| freeze_i | input | 1 | Freeze request, acted on at picture starts |
| err_frame_only_i | input | 1 | Restrict err_no to framing errors |
| cnt_clr_i | input | 1 | Clear the fault count |
| locked_o | output | 1 | Lock status |
| err_no | output | 1 | Error pulse, active low |
| fault_cnt_o | output | 9 | Saturating fault count |
| cur_gob_o | output | 4 | Internal GOB number (0 = none since picture start) |
| fill_valid_o | output | 1 | Fixed-macroblock fill request |
| fill_gob_o | output | 4 | GOB to fill |
| parser_en_o | output | 1 | Parser may consume the stream |

## Verification
A wrong sequence state first shows up at `cur_gob_o`, one cycle after the GOB start that should have ended checking or advanced the count. It shows up a second time as a wrong fill list after the next loss and regain. A wrong lock state appears at `locked_o` in the cycle after the event. It also appears in the fill burst or its absence, which starts in that same cycle and lasts up to a full picture of GOBs. Counter faults are visible only at `fault_cnt_o`, so the saturation corner needs more than 256 counted losses to expose.

// File: rtl/gob_lock_pkg.sv
package gob_lock_pkg;
  localparam int unsigned GOB_W     = 4;
  localparam int unsigned CIF_GOBS  = 12;
  localparam int unsigned QCIF_GOBS = 3;

  localparam logic [GOB_W-1:0] FIRST_GOB = GOB_W'(1);
  localparam logic [GOB_W-1:0] CIF_LAST  = GOB_W'(CIF_GOBS);
  localparam logic [GOB_W-1:0] QCIF_LAST = GOB_W'(2 * QCIF_GOBS - 1);

  typedef enum logic [1:0] {
    SEQ_NONE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_OK   = 2'd2
  } seq_state_e;

  function automatic logic [GOB_W-1:0] last_gob(input logic qcif);
    return qcif ? QCIF_LAST : CIF_LAST;
  endfunction

  function automatic logic [GOB_W-1:0] next_gob(input logic [GOB_W-1:0] n, input logic qcif);
    logic [GOB_W-1:0] r;
    if (qcif) begin
      if (n == '0 || n >= QCIF_LAST) r = FIRST_GOB;
      else                           r = n + GOB_W'(2);
    end else begin
      if (n >= CIF_LAST) r = FIRST_GOB;
      else               r = n + GOB_W'(1);
    end
    return r;
  endfunction

  function automatic logic gob_valid(input logic [GOB_W-1:0] n, input logic qcif);
    if (qcif) return n[0] && (n <= QCIF_LAST);
    return (n != '0) && (n <= CIF_LAST);
  endfunction
endpackage

// File: rtl/glc_fault_cnt.sv
module glc_fault_cnt #(
  parameter  int unsigned CNT_MAX = 256,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));
endmodule

// File: rtl/glc_seq_track.sv
module glc_seq_track import gob_lock_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qcif_i,
  input  logic             reset_i,   // new lock from picture: none seen, restart checking
  input  logic             pic_i,     // normal picture boundary
  input  logic             load_i,    // new lock from GOB start
  input  logic             step_i,
  input  logic [GOB_W-1:0] num_i,
  output logic [GOB_W-1:0] cur_o
);
  seq_state_e       st_q;
  logic [GOB_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_NONE;
      cur_q <= '0;
    end else if (reset_i) begin
      st_q  <= SEQ_NONE;
      cur_q <= '0;
    end else if (load_i) begin
      st_q  <= SEQ_ONE;
      cur_q <= num_i;
    end else if (pic_i) begin
      cur_q <= '0;
    end else if (step_i) begin
      unique case (st_q)
        SEQ_NONE: begin
          st_q  <= SEQ_ONE;
          cur_q <= num_i;
        end
        SEQ_ONE: begin
          if (num_i == next_gob(cur_q, qcif_i)) st_q <= SEQ_OK;
          cur_q <= num_i;
        end
        default: cur_q <= next_gob(cur_q, qcif_i);
      endcase
    end
  end

  assign cur_o = cur_q;

  // R5
  seq_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reset_i && !load_i && !pic_i && st_q != SEQ_OK) |=> (cur_q == $past(num_i)));
endmodule

// File: rtl/glc_fill_gen.sv
module glc_fill_gen import gob_lock_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qcif_i,
  input  logic             go_i,
  input  logic [GOB_W-1:0] first_i,
  input  logic [GOB_W-1:0] stop_i,   // exclusive end
  input  logic             full_i,   // first == stop means a whole picture
  output logic             busy_o,
  output logic [GOB_W-1:0] gob_o
);
  logic             busy_q;
  logic [GOB_W-1:0] gob_q, stop_q, nxt;

  assign nxt = next_gob(gob_q, qcif_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gob_q  <= '0;
      stop_q <= '0;
    end else if (busy_q) begin
      if (nxt == stop_q) busy_q <= 1'b0;
      else               gob_q  <= nxt;
    end else if (go_i && (first_i != stop_i || full_i)) begin
      busy_q <= 1'b1;
      gob_q  <= first_i;
      stop_q <= stop_i;
    end
  end

  assign busy_o = busy_q;
  assign gob_o  = gob_q;

  // R10
  fill_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> gob_valid(gob_q, qcif_i));
endmodule

// File: rtl/gob_lock_ctrl.sv
module gob_lock_ctrl import gob_lock_pkg::*; #(
  parameter  int unsigned CNT_MAX = 256,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pic_start_i,
  input  logic             gob_start_i,
  input  logic [GOB_W-1:0] gob_num_i,
  input  logic             flt_missing_i,
  input  logic             flt_nomatch_i,
  input  logic             flt_coef_i,
  input  logic             frame_err_i,
  input  logic             qcif_i,
  input  logic             recover_gob_i,
  input  logic             hold_i,
  input  logic             freeze_i,
  input  logic             err_frame_only_i,
  input  logic             cnt_clr_i,
  output logic             locked_o,
  output logic             err_no,
  output logic [CNT_W-1:0] fault_cnt_o,
  output logic [GOB_W-1:0] cur_gob_o,
  output logic             fill_valid_o,
  output logic [GOB_W-1:0] fill_gob_o,
  output logic             parser_en_o
);
  logic locked_q, relock_q, need_pic_q, seen_pic_q, freeze_q, hold_q, err_nq;
  logic locked_d, relock_d, need_pic_d, seen_pic_d, freeze_d;
  logic cnt_inc, lock_err, err_evt;
  logic fill_go, fill_full, fill_busy;
  logic [GOB_W-1:0] fill_first, fill_stop, cur_gob;
  logic seq_reset, seq_pic, seq_load, seq_step;
  logic any_flt, num_ok;

  assign any_flt = flt_missing_i | flt_nomatch_i | flt_coef_i;
  assign num_ok  = gob_valid(gob_num_i, qcif_i);

  always_comb begin
    locked_d   = locked_q;
    relock_d   = 1'b0;
    need_pic_d = need_pic_q;
    seen_pic_d = seen_pic_q;
    freeze_d   = freeze_q;
    cnt_inc    = 1'b0;
    lock_err   = 1'b0;
    fill_go    = 1'b0;
    fill_first = next_gob(cur_gob, qcif_i);
    fill_stop  = FIRST_GOB;
    fill_full  = 1'b0;
    seq_reset  = 1'b0;
    seq_pic    = 1'b0;
    seq_load   = 1'b0;
    seq_step   = 1'b0;
    if (hold_i) begin
      locked_d   = 1'b0;
      need_pic_d = 1'b1;
    end else if (relock_q) begin
      locked_d = 1'b1;
    end else if (locked_q) begin
      if (any_flt) begin
        locked_d = 1'b0;
        cnt_inc  = 1'b1;
        lock_err = 1'b1;
      end else if (gob_start_i && !num_ok) begin
        locked_d = 1'b0;
        lock_err = 1'b1;
      end else if (pic_start_i) begin
        if (freeze_i) begin
          locked_d = 1'b0;
          freeze_d = 1'b1;
        end else if (cur_gob != last_gob(qcif_i)) begin
          // unexpected picture start: drop one cycle, resync
          locked_d  = 1'b0;
          relock_d  = 1'b1;
          cnt_inc   = 1'b1;
          lock_err  = 1'b1;
          fill_go   = 1'b1;
          fill_full = (cur_gob == '0);
          seq_reset = 1'b1;
        end else begin
          seq_pic = 1'b1;
        end
      end else if (gob_start_i) begin
        seq_step = 1'b1;
      end
    end else begin
      if (pic_start_i) begin
        if (freeze_i) begin
          freeze_d = 1'b1;
        end else begin
          locked_d   = 1'b1;
          need_pic_d = 1'b0;
          seen_pic_d = 1'b1;
          freeze_d   = 1'b0;
          seq_reset  = 1'b1;
          if (seen_pic_q && !freeze_q) begin
            fill_go   = 1'b1;
            fill_full = (cur_gob == '0);
          end
        end
      end else if (gob_start_i && num_ok && recover_gob_i && !need_pic_q && !freeze_q) begin
        locked_d  = 1'b1;
        seq_load  = 1'b1;
        fill_go   = 1'b1;
        fill_stop = gob_num_i;
      end
    end
  end

  assign err_evt = err_frame_only_i ? frame_err_i : (lock_err | frame_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      relock_q   <= 1'b0;
      need_pic_q <= 1'b1;
      seen_pic_q <= 1'b0;
      freeze_q   <= 1'b0;
      hold_q     <= 1'b0;
      err_nq     <= 1'b1;
    end else begin
      locked_q   <= locked_d;
      relock_q   <= relock_d;
      need_pic_q <= need_pic_d;
      seen_pic_q <= seen_pic_d;
      freeze_q   <= freeze_d;
      hold_q     <= hold_i;
      err_nq     <= ~err_evt;
    end
  end

  glc_fault_cnt #(.CNT_MAX(CNT_MAX)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cnt_inc),
    .clr_i  (cnt_clr_i),
    .cnt_o  (fault_cnt_o)
  );

  glc_seq_track u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .qcif_i  (qcif_i),
    .reset_i (seq_reset),
    .pic_i   (seq_pic),
    .load_i  (seq_load),
    .step_i  (seq_step),
    .num_i   (gob_num_i),
    .cur_o   (cur_gob)
  );

  glc_fill_gen u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .qcif_i  (qcif_i),
    .go_i    (fill_go),
    .first_i (fill_first),
    .stop_i  (fill_stop),
    .full_i  (fill_full),
    .busy_o  (fill_busy),
    .gob_o   (fill_gob_o)
  );

  assign locked_o     = locked_q;
  assign err_no       = err_nq;
  assign cur_gob_o    = cur_gob;
  assign fill_valid_o = fill_busy;
  assign parser_en_o  = ~fill_busy & ~hold_q;

  // R7
  hold_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !locked_q);

  // R1
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(pic_start_i || gob_start_i || relock_q));

  // R4
  relock_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relock_q && !hold_i) |=> locked_q);
endmodule

// File: tb/gob_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module gob_lock_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pic = 0, gob = 0, f_miss = 0, f_nom = 0, f_coef = 0, f_frm = 0;
  logic qcif = 0, rec_gob = 0, hold = 0, frz = 0, frm_only = 0, clr = 0;
  logic [3:0] num = 0;
  logic locked, err_n, fvalid, pen;
  logic [8:0] cnt;
  logic [3:0] cur, fgob;
  int n_chk = 0, n_fail = 0;
  int fill_q[$];

  always #2.5 clk = ~clk;

  gob_lock_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pic_start_i(pic), .gob_start_i(gob), .gob_num_i(num),
    .flt_missing_i(f_miss), .flt_nomatch_i(f_nom), .flt_coef_i(f_coef), .frame_err_i(f_frm),
    .qcif_i(qcif), .recover_gob_i(rec_gob), .hold_i(hold), .freeze_i(frz),
    .err_frame_only_i(frm_only), .cnt_clr_i(clr), .locked_o(locked), .err_no(err_n),
    .fault_cnt_o(cnt), .cur_gob_o(cur), .fill_valid_o(fvalid), .fill_gob_o(fgob),
    .parser_en_o(pen));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected fill items
  always @(negedge clk) begin
    if (rst_n && fvalid) begin
      if (fill_q.size() == 0) chk("R10 unexpected fill gob", int'(fgob), 0);
      else chk("R10 fill gob", int'(fgob), fill_q.pop_front());
    end
  end

  task automatic push(input int g);
    fill_q.push_back(g);
  endtask

  task automatic ev_pic();
    @(negedge clk) pic = 1;
    @(negedge clk) pic = 0;
  endtask

  task automatic ev_gob(input int n);
    @(negedge clk) begin gob = 1; num = 4'(n); end
    @(negedge clk) gob = 0;
  endtask

  task automatic ev_flt(input int k);
    @(negedge clk) begin f_miss = (k == 0); f_nom = (k == 1); f_coef = (k == 2); end
    @(negedge clk) begin f_miss = 0; f_nom = 0; f_coef = 0; end
  endtask

  task automatic wait_fill();
    while (!pen) @(negedge clk);
    chk("R10 fill list drained", fill_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset locked", locked, 0);
    chk("R1 reset err_no", err_n, 1);
    chk("R1 reset count", cnt, 0);
    chk("R1 reset fill", fvalid, 0);
    chk("R1 reset parser_en", pen, 1);
    chk("R1 reset cur", cur, 0);

    ev_gob(1);
    chk("R1 gob before picture ignored", locked, 0);
    ev_pic();
    chk("R1 first lock on picture", locked, 1);
    chk("R1 no fill on first lock", fvalid, 0);
    ev_gob(1); chk("R5 first gob taken", cur, 1);
    ev_gob(2); chk("R5 in sequence", cur, 2);
    ev_gob(7); chk("R6 stream number ignored", cur, 3);

    ev_flt(1);
    chk("R2 fault unlocks", locked, 0);
    chk("R2 fault counted", cnt, 1);
    chk("R11 err low", err_n, 0);
    @(negedge clk) chk("R11 err one cycle", err_n, 1);
    ev_flt(2);
    chk("R2 fault while unlocked ignored", cnt, 1);

    for (int g = 4; g <= 12; g++) push(g);
    ev_pic();
    chk("R8 picture recovery", locked, 1);
    chk("R10 parser gated while filling", pen, 0);
    wait_fill();

    ev_gob(1); ev_gob(2); ev_gob(3);
    for (int g = 4; g <= 12; g++) push(g);
    ev_pic();
    chk("R4 drop one cycle", locked, 0);
    chk("R4 counted", cnt, 2);
    chk("R4 err", err_n, 0);
    @(negedge clk) chk("R4 relocked", locked, 1);
    wait_fill();
    chk("R4 cur reset", cur, 0);

    rec_gob = 1;
    ev_gob(1); ev_gob(2); ev_gob(3);
    ev_flt(2);
    chk("R2 coef fault counted", cnt, 3);
    push(4); push(5);
    ev_gob(6);
    chk("R8 gob recovery", locked, 1);
    chk("R8 gob number taken", cur, 6);
    wait_fill();
    ev_gob(9);  chk("R5 new sequence", cur, 9);
    ev_gob(10); chk("R5 sequence confirmed", cur, 10);
    ev_gob(4);  chk("R6 own numbering", cur, 11);

    ev_gob(13);
    chk("R9 range unlocks", locked, 0);
    chk("R9 range not counted", cnt, 3);
    chk("R9 range err", err_n, 0);
    ev_gob(12);
    chk("R10 no gap no fill", fvalid, 0);
    chk("R8 relock at 12", locked, 1);

    @(negedge clk) hold = 1;
    @(negedge clk);
    chk("R7 hold unlocks", locked, 0);
    chk("R7 hold gates parser", pen, 0);
    ev_pic();
    chk("R7 picture ignored during hold", locked, 0);
    @(negedge clk) hold = 0;
    @(negedge clk);
    ev_gob(1);
    chk("R7 gob cannot relock after hold", locked, 0);
    ev_pic();
    chk("R7 picture relocks after hold", locked, 1);
    chk("R10 no fill after full picture", fvalid, 0);

    frm_only = 1;
    ev_flt(0);
    chk("R2 missing fault counted", cnt, 4);
    chk("R11 frame-only masks fault", err_n, 1);
    @(negedge clk) f_frm = 1;
    @(negedge clk) f_frm = 0;
    chk("R11 frame error pulses", err_n, 0);
    frm_only = 0;

    qcif = 1; rec_gob = 0;
    push(1); push(3); push(5);
    ev_pic();
    chk("R10 whole picture fill", locked, 1);
    wait_fill();
    ev_gob(1); ev_gob(3); ev_gob(5);
    chk("R6 qcif numbering", cur, 5);
    frz = 1;
    ev_pic(); chk("R12 freeze unlocks", locked, 0);
    ev_pic(); chk("R12 freeze holds", locked, 0);
    frz = 0;
    ev_pic();
    chk("R12 release relocks", locked, 1);
    chk("R12 no fill on release", fvalid, 0);
    ev_gob(1);
    ev_gob(2);
    chk("R9 qcif even number unlocks", locked, 0);
    chk("R9 count unchanged", cnt, 4);

    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R3 clear", cnt, 0);
    for (int i = 0; i < 260; i++) begin
      if (i == 0) begin push(3); push(5); end
      else begin push(1); push(3); push(5); end
      ev_pic();
      wait_fill();
      ev_flt(1);
      if (i == 254) chk("R3 count below limit", cnt, 255);
    end
    chk("R3 saturated", cnt, 256);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R3 clear after saturation", cnt, 0);

    repeat (4) @(negedge clk);
    chk("R10 no stray fill", fill_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule